// File: doc/BRIEF.md
# Spike-Timing Plasticity Event Queue Engine

This block learns synaptic weights from the relative timing of spikes, and it does so outside the neuron array. It keeps two short histories of recent spikes. One history holds presynaptic spikes and the other holds postsynaptic spikes. Each stored spike carries a neuron address and a timing value. The timing value starts at a configured window length and counts down on every tick of an external time-step strobe. When it reaches zero it stays there.

Each incoming spike triggers a search of the other history, from the newest entry to the oldest. A postsynaptic spike finds the presynaptic spikes that led it and strengthens those synapses. A presynaptic spike finds the postsynaptic spikes that came just before it and weakens those synapses. Each match produces one update command on the output port, at most one per cycle. The command carries the presynaptic address, the postsynaptic address, a sign, and an amount. The amount is the timing value scaled by a right shift.

After its search, the triggering spike is stored in its own history. The weight memory receives the commands and keeps the weights. For stable learning, the depression window must be configured wider than the potentiation window.

Top module: `stdp_queue_engine`

## Requirements
- R1: Out of reset, `spk_ready` is 1, `upd_valid` is 0, and both histories are empty. A first spike of either kind therefore produces no update.
- R2: The block keeps two separate histories of 8 entries each. A stored presynaptic spike (`spk_post`=0) gets timing value `cfg_tau_plus`. A stored postsynaptic spike (`spk_post`=1) gets timing value `cfg_tau_minus`.
- R3: Each cycle with `tick`=1 lowers every stored timing value by one. A value never goes below zero.
- R4: A postsynaptic spike walks the presynaptic history from newest to oldest. Each live entry gives one update with `upd_dec`=0, `upd_pre_addr` set to the entry's address, and `upd_post_addr` set to the spike's address. Updates appear one per cycle. The first update appears in the cycle after the buffered spike is taken, and amounts do not grow along a walk.
- R5: A presynaptic spike walks the postsynaptic history in the same way. Each live entry gives an update with `upd_dec`=1, `upd_pre_addr` set to the spike's address, and `upd_post_addr` set to the entry's address.
- R6: `upd_amount` equals the entry's timing value shifted right by `cfg_eta_shift`.
- R7: A walk ends at the first entry whose timing value is zero, or after the oldest stored entry. A walk gives at most 8 updates.
- R8: When a history already holds 8 entries, a new spike replaces its oldest entry.
- R9: A spike is accepted when `spk_valid` and `spk_ready` are both 1. An accepted spike fills a one-deep buffer, and `spk_ready` stays 0 until the engine takes that spike. A spike accepted during a walk is processed after it, and no spike is lost.
- R10: The triggering spike is stored only after its own walk completes. The next spike of the other kind then sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-step strobe; each high cycle lowers all timing values by one |
| spk_valid | input | 1 | Spike offered |
| spk_ready | output | 1 | Input buffer is empty and can accept a spike |
| spk_post | input | 1 | 1 = postsynaptic spike, 0 = presynaptic spike |
| spk_addr | input | 6 | Neuron address of the spike |
| cfg_tau_plus | input | 8 | Starting timing value for presynaptic entries |
| cfg_tau_minus | input | 8 | Starting timing value for postsynaptic entries |
| cfg_eta_shift | input | 3 | Right shift that turns a timing value into an amount |
| upd_valid | output | 1 | An update command is present this cycle |
| upd_dec | output | 1 | 1 = decrement the weight, 0 = increment it |
| upd_pre_addr | output | 6 | Presynaptic address of the synapse |
| upd_post_addr | output | 6 | Postsynaptic address of the synapse |
| upd_amount | output | 8 | Size of the weight change |

## Verification
The first spike of each kind goes into an empty opposite history. This shows that nothing is paired with stale or reset state, and that the spike is stored only after its own walk. Single-entry pairings in both directions separate the sign and address orientation of increments from those of decrements. Multi-entry walks after a number of ticks check newest-first order, the decay, and the shift. A long run of ticks drives timing values to zero, which separates saturation from wrap-around and shows that a walk stops at a dead entry. Nine postsynaptic spikes followed by one presynaptic spike expose whether the oldest entry is replaced. Two back-to-back presynaptic spikes show the back-pressure and that the held spike is still processed.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_PUSH = 2'd2
  } walk_st_e;

  localparam int unsigned QSEL_PRE  = 0;
  localparam int unsigned QSEL_POST = 1;
  localparam int unsigned NUM_Q     = 2;

endpackage

// File: rtl/stdp_spike_buf.sv
module stdp_spike_buf #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic              in_post_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  output logic              in_ready_o,
  input  logic              take_i,
  output logic              out_valid_o,
  output logic              out_post_o,
  output logic [ADDR_W-1:0] out_addr_o
);

  logic              v_q, v_d;
  logic              post_q, post_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              accept;

  assign in_ready_o  = ~v_q;
  assign accept      = in_valid_i & ~v_q;
  assign out_valid_o = v_q;
  assign out_post_o  = post_q;
  assign out_addr_o  = addr_q;

  always_comb begin
    v_d    = v_q;
    post_d = post_q;
    addr_d = addr_q;
    if (take_i) begin
      v_d = 1'b0;
    end
    if (accept) begin
      v_d    = 1'b1;
      post_d = in_post_i;
      addr_d = in_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      post_q <= 1'b0;
      addr_q <= '0;
    end else begin
      v_q <= v_d;
      if (accept) begin
        post_q <= post_d;
        addr_q <= addr_d;
      end
    end
  end

endmodule

// File: rtl/stdp_event_queue.sv
module stdp_event_queue #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned PHI_W  = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [PHI_W-1:0]  push_phi_i,
  input  logic [IDX_W-1:0]  rd_age_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [PHI_W-1:0]  rd_phi_o,
  output logic              rd_live_o
);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [ADDR_W-1:0] addr_d [DEPTH];
  logic [PHI_W-1:0]  phi_q  [DEPTH];
  logic [PHI_W-1:0]  phi_d  [DEPTH];
  logic [IDX_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  rd_idx;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic sel_wr;
    assign sel_wr = push_i && (wr_ptr_q == IDX_W'(e));

    always_comb begin
      phi_d[e]  = phi_q[e];
      addr_d[e] = addr_q[e];
      if (tick_i && (phi_q[e] != '0)) begin
        phi_d[e] = phi_q[e] - PHI_W'(1);
      end
      if (sel_wr) begin
        phi_d[e]  = push_phi_i;
        addr_d[e] = push_addr_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        phi_q[e]  <= '0;
        addr_q[e] <= '0;
      end else begin
        if (tick_i || sel_wr) begin
          phi_q[e] <= phi_d[e];
        end
        if (sel_wr) begin
          addr_q[e] <= addr_d[e];
        end
      end
    end
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (push_i) begin
      wr_ptr_d = wr_ptr_q + IDX_W'(1);
      if (cnt_q != CNT_W'(DEPTH)) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (push_i) begin
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign rd_idx    = wr_ptr_q - IDX_W'(1) - rd_age_i;
  assign rd_addr_o = addr_q[rd_idx];
  assign rd_phi_o  = phi_q[rd_idx];
  assign rd_live_o = ({1'b0, rd_age_i} < cnt_q);

endmodule

// File: rtl/stdp_walk_ctrl.sv
module stdp_walk_ctrl
  import stdp_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned PHI_W  = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned SH_W  = $clog2(PHI_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid_i,
  input  logic              ev_post_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  output logic              ev_take_o,
  output logic              cur_post_o,
  output logic [IDX_W-1:0]  rd_age_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [PHI_W-1:0]  rd_phi_i,
  input  logic              rd_live_i,
  input  logic [PHI_W-1:0]  tau_plus_i,
  input  logic [PHI_W-1:0]  tau_minus_i,
  input  logic [SH_W-1:0]   eta_shift_i,
  output logic              push_pre_o,
  output logic              push_post_o,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic [PHI_W-1:0]  push_phi_o,
  output logic              upd_valid_o,
  output logic              upd_dec_o,
  output logic [ADDR_W-1:0] upd_pre_addr_o,
  output logic [ADDR_W-1:0] upd_post_addr_o,
  output logic [PHI_W-1:0]  upd_amount_o
);

  walk_st_e          st_q, st_d;
  logic [IDX_W-1:0]  age_q, age_d;
  logic              cur_post_q, cur_post_d;
  logic [ADDR_W-1:0] cur_addr_q, cur_addr_d;
  logic              hit;
  logic              last_age;
  logic              cur_en;

  assign hit      = (st_q == ST_WALK) && rd_live_i && (rd_phi_i != '0);
  assign last_age = (age_q == IDX_W'(DEPTH - 1));

  always_comb begin
    st_d       = st_q;
    age_d      = age_q;
    cur_post_d = cur_post_q;
    cur_addr_d = cur_addr_q;
    cur_en     = 1'b0;
    ev_take_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ev_valid_i) begin
          ev_take_o  = 1'b1;
          cur_en     = 1'b1;
          cur_post_d = ev_post_i;
          cur_addr_d = ev_addr_i;
          age_d      = '0;
          st_d       = ST_WALK;
        end
      end
      ST_WALK: begin
        if (hit && !last_age) begin
          age_d = age_q + IDX_W'(1);
        end else begin
          st_d = ST_PUSH;
        end
      end
      ST_PUSH: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      age_q      <= '0;
      cur_post_q <= 1'b0;
      cur_addr_q <= '0;
    end else begin
      st_q  <= st_d;
      age_q <= age_d;
      if (cur_en) begin
        cur_post_q <= cur_post_d;
        cur_addr_q <= cur_addr_d;
      end
    end
  end

  assign cur_post_o      = cur_post_q;
  assign rd_age_o        = age_q;
  assign push_pre_o      = (st_q == ST_PUSH) && !cur_post_q;
  assign push_post_o     = (st_q == ST_PUSH) &&  cur_post_q;
  assign push_addr_o     = cur_addr_q;
  assign push_phi_o      = cur_post_q ? tau_minus_i : tau_plus_i;
  assign upd_valid_o     = hit;
  assign upd_dec_o       = ~cur_post_q;
  assign upd_pre_addr_o  = cur_post_q ? rd_addr_i  : cur_addr_q;
  assign upd_post_addr_o = cur_post_q ? cur_addr_q : rd_addr_i;
  assign upd_amount_o    = rd_phi_i >> eta_shift_i;

endmodule

// File: rtl/stdp_queue_engine.sv
module stdp_queue_engine
  import stdp_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned PHI_W  = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned SH_W  = $clog2(PHI_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              spk_valid,
  output logic              spk_ready,
  input  logic              spk_post,
  input  logic [ADDR_W-1:0] spk_addr,
  input  logic [PHI_W-1:0]  cfg_tau_plus,
  input  logic [PHI_W-1:0]  cfg_tau_minus,
  input  logic [SH_W-1:0]   cfg_eta_shift,
  output logic              upd_valid,
  output logic              upd_dec,
  output logic [ADDR_W-1:0] upd_pre_addr,
  output logic [ADDR_W-1:0] upd_post_addr,
  output logic [PHI_W-1:0]  upd_amount
);

  logic              ev_valid;
  logic              ev_post;
  logic [ADDR_W-1:0] ev_addr;
  logic              ev_take;
  logic              cur_post;
  logic [IDX_W-1:0]  rd_age;
  logic              push_pre, push_post;
  logic [ADDR_W-1:0] push_addr;
  logic [PHI_W-1:0]  push_phi;

  logic              q_push    [NUM_Q];
  logic [ADDR_W-1:0] q_rd_addr [NUM_Q];
  logic [PHI_W-1:0]  q_rd_phi  [NUM_Q];
  logic              q_rd_live [NUM_Q];

  logic [ADDR_W-1:0] sel_addr;
  logic [PHI_W-1:0]  sel_phi;
  logic              sel_live;

  stdp_spike_buf #(
    .ADDR_W (ADDR_W)
  ) in_buf_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (spk_valid),
    .in_post_i   (spk_post),
    .in_addr_i   (spk_addr),
    .in_ready_o  (spk_ready),
    .take_i      (ev_take),
    .out_valid_o (ev_valid),
    .out_post_o  (ev_post),
    .out_addr_o  (ev_addr)
  );

  assign q_push[QSEL_PRE]  = push_pre;
  assign q_push[QSEL_POST] = push_post;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    stdp_event_queue #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .PHI_W  (PHI_W)
    ) queue_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .push_i      (q_push[q]),
      .push_addr_i (push_addr),
      .push_phi_i  (push_phi),
      .rd_age_i    (rd_age),
      .rd_addr_o   (q_rd_addr[q]),
      .rd_phi_o    (q_rd_phi[q]),
      .rd_live_o   (q_rd_live[q])
    );
  end

  // A postsynaptic trigger searches the presynaptic history, and vice versa.
  always_comb begin
    if (cur_post) begin
      sel_addr = q_rd_addr[QSEL_PRE];
      sel_phi  = q_rd_phi[QSEL_PRE];
      sel_live = q_rd_live[QSEL_PRE];
    end else begin
      sel_addr = q_rd_addr[QSEL_POST];
      sel_phi  = q_rd_phi[QSEL_POST];
      sel_live = q_rd_live[QSEL_POST];
    end
  end

  stdp_walk_ctrl #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .PHI_W  (PHI_W)
  ) walk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .ev_valid_i      (ev_valid),
    .ev_post_i       (ev_post),
    .ev_addr_i       (ev_addr),
    .ev_take_o       (ev_take),
    .cur_post_o      (cur_post),
    .rd_age_o        (rd_age),
    .rd_addr_i       (sel_addr),
    .rd_phi_i        (sel_phi),
    .rd_live_i       (sel_live),
    .tau_plus_i      (cfg_tau_plus),
    .tau_minus_i     (cfg_tau_minus),
    .eta_shift_i     (cfg_eta_shift),
    .push_pre_o      (push_pre),
    .push_post_o     (push_post),
    .push_addr_o     (push_addr),
    .push_phi_o      (push_phi),
    .upd_valid_o     (upd_valid),
    .upd_dec_o       (upd_dec),
    .upd_pre_addr_o  (upd_pre_addr),
    .upd_post_addr_o (upd_post_addr),
    .upd_amount_o    (upd_amount)
  );

endmodule

// File: rtl/stdp_queue_engine_chk.sv
module stdp_queue_engine_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned PHI_W  = 8,
  localparam int unsigned SH_W  = $clog2(PHI_W),
  localparam int unsigned RUN_W = $clog2(DEPTH) + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spk_valid,
  input logic              spk_ready,
  input logic [PHI_W-1:0]  cfg_tau_plus,
  input logic [PHI_W-1:0]  cfg_tau_minus,
  input logic [SH_W-1:0]   cfg_eta_shift,
  input logic              upd_valid,
  input logic              upd_dec,
  input logic [ADDR_W-1:0] upd_pre_addr,
  input logic [ADDR_W-1:0] upd_post_addr,
  input logic [PHI_W-1:0]  upd_amount
);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (upd_valid) begin
      run_q <= run_q + RUN_W'(1);
    end else begin
      run_q <= '0;
    end
  end

  AST_ACCEPT_FILLS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (spk_valid && spk_ready) |=> !spk_ready); // R9

  AST_WALK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (run_q < RUN_W'(DEPTH))); // R7

  AST_INC_POST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && $past(upd_valid) && !upd_dec) |-> ($stable(upd_post_addr) && $stable(upd_dec))); // R4

  AST_DEC_PRE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && $past(upd_valid) && upd_dec) |-> ($stable(upd_pre_addr) && $stable(upd_dec))); // R5

  AST_AMOUNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_amount <= ((upd_dec ? cfg_tau_minus : cfg_tau_plus) >> cfg_eta_shift))); // R6

  AST_AMOUNT_NONRISING: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && $past(upd_valid)) |-> (upd_amount <= $past(upd_amount))); // R4

endmodule

bind stdp_queue_engine stdp_queue_engine_chk #(
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W),
  .PHI_W  (PHI_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .spk_valid     (spk_valid),
  .spk_ready     (spk_ready),
  .cfg_tau_plus  (cfg_tau_plus),
  .cfg_tau_minus (cfg_tau_minus),
  .cfg_eta_shift (cfg_eta_shift),
  .upd_valid     (upd_valid),
  .upd_dec       (upd_dec),
  .upd_pre_addr  (upd_pre_addr),
  .upd_post_addr (upd_post_addr),
  .upd_amount    (upd_amount)
);

// File: tb/stdp_queue_engine_tb_top.sv
module stdp_queue_engine_tb_top;

  localparam int unsigned DEPTH  = 8;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned PHI_W  = 8;
  localparam int unsigned SH_W   = 3;
  localparam int unsigned LOG_N  = 32;

  logic              clk;
  logic              rst_n;
  logic              tick;
  logic              spk_valid;
  logic              spk_ready;
  logic              spk_post;
  logic [ADDR_W-1:0] spk_addr;
  logic [PHI_W-1:0]  cfg_tau_plus;
  logic [PHI_W-1:0]  cfg_tau_minus;
  logic [SH_W-1:0]   cfg_eta_shift;
  logic              upd_valid;
  logic              upd_dec;
  logic [ADDR_W-1:0] upd_pre_addr;
  logic [ADDR_W-1:0] upd_post_addr;
  logic [PHI_W-1:0]  upd_amount;

  int errors;
  int checks;
  int log_n;
  int log_pre  [LOG_N];
  int log_post [LOG_N];
  int log_dec  [LOG_N];
  int log_amt  [LOG_N];

  stdp_queue_engine #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .PHI_W  (PHI_W)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .spk_valid     (spk_valid),
    .spk_ready     (spk_ready),
    .spk_post      (spk_post),
    .spk_addr      (spk_addr),
    .cfg_tau_plus  (cfg_tau_plus),
    .cfg_tau_minus (cfg_tau_minus),
    .cfg_eta_shift (cfg_eta_shift),
    .upd_valid     (upd_valid),
    .upd_dec       (upd_dec),
    .upd_pre_addr  (upd_pre_addr),
    .upd_post_addr (upd_post_addr),
    .upd_amount    (upd_amount)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && upd_valid && (log_n < LOG_N)) begin
      log_pre[log_n]  = int'(upd_pre_addr);
      log_post[log_n] = int'(upd_post_addr);
      log_dec[log_n]  = int'(upd_dec);
      log_amt[log_n]  = int'(upd_amount);
      log_n           = log_n + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    tick      = 1'b0;
    spk_valid = 1'b0;
    spk_post  = 1'b0;
    spk_addr  = '0;
    log_n     = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Starts and ends on a falling edge.
  task automatic send(input logic post, input int addr);
    spk_valid = 1'b1;
    spk_post  = post;
    spk_addr  = ADDR_W'(addr);
    while (!spk_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    spk_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (DEPTH + 6) @(negedge clk);
  endtask

  task automatic spike(input logic post, input int addr);
    log_n = 0;
    send(post, addr);
    settle();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic exp_upd(input string req, input int idx, input int pre, input int post,
                         input int dec, input int amt);
    chk(req, $sformatf("update %0d pre address", idx), log_pre[idx], pre);
    chk(req, $sformatf("update %0d post address", idx), log_post[idx], post);
    chk(req, $sformatf("update %0d sign", idx), log_dec[idx], dec);
    chk(req, $sformatf("update %0d amount", idx), log_amt[idx], amt);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "spk_ready after reset", int'(spk_ready), 1);
    chk("R1", "upd_valid after reset", int'(upd_valid), 0);
  endtask

  task automatic t_first_pairs();
    cfg_eta_shift = 3'd1;
    spike(1'b0, 3);
    chk("R1", "updates from first pre spike", log_n, 0);
    spike(1'b1, 5);
    chk("R4", "update count post spike", log_n, 1);
    exp_upd("R4", 0, 3, 5, 0, 5);
  endtask

  task automatic t_depress_after_push();
    spike(1'b0, 7);
    chk("R10", "update count pre spike sees earlier post", log_n, 1);
    exp_upd("R5", 0, 7, 5, 1, 10);
  endtask

  task automatic t_decay_order();
    ticks(4);
    spike(1'b1, 9);
    chk("R3", "update count after decay", log_n, 2);
    exp_upd("R4", 0, 7, 9, 0, 3);
    exp_upd("R3", 1, 3, 9, 0, 3);
  endtask

  task automatic t_saturate_stop();
    ticks(12);
    spike(1'b1, 11);
    chk("R7", "updates when newest entry is zero", log_n, 0);
    spike(1'b0, 2);
    chk("R3", "update count after long decay", log_n, 3);
    exp_upd("R5", 0, 2, 11, 1, 10);
    exp_upd("R3", 1, 2, 9, 1, 4);
    exp_upd("R3", 2, 2, 5, 1, 2);
  endtask

  task automatic t_overwrite();
    do_reset();
    cfg_eta_shift = 3'd2;
    for (int a = 1; a <= 9; a++) begin
      spike(1'b1, a);
    end
    spike(1'b0, 0);
    chk("R8", "update count from full history", log_n, DEPTH);
    for (int k = 0; k < 8; k++) begin
      exp_upd("R8", k, 0, 9 - k, 1, 5);
    end
    chk("R6", "amount with shift 2", log_amt[0], 5);
  endtask

  task automatic t_backpressure();
    do_reset();
    cfg_eta_shift = 3'd1;
    log_n = 0;
    send(1'b0, 20);
    chk("R9", "spk_ready while buffer full", int'(spk_ready), 0);
    send(1'b0, 21);
    chk("R9", "spk_ready after second accept", int'(spk_ready), 0);
    settle();
    chk("R9", "spk_ready when drained", int'(spk_ready), 1);
    chk("R9", "updates from pre spikes", log_n, 0);
    spike(1'b1, 30);
    chk("R9", "update count held spike kept", log_n, 2);
    exp_upd("R9", 0, 21, 30, 0, 5);
    exp_upd("R2", 1, 20, 30, 0, 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors        = 0;
    checks        = 0;
    cfg_tau_plus  = 8'd10;
    cfg_tau_minus = 8'd20;
    cfg_eta_shift = 3'd1;
    t_reset_state();
    t_first_pairs();
    t_depress_after_push();
    t_decay_order();
    t_saturate_stop();
    t_overwrite();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule